// File: doc/BRIEF.md
# Bus Initiator Cycle Sequencer

This block turns a single local processor access into one initiator transaction on a parallel, PCI-style shared bus. The processor pulses a start strobe and supplies the top four address bits, an I/O-versus-memory flag, a write flag and active-low byte enables. The block works out the bus command from these. It drives FRAME, the address-bus enable and the command for exactly one address cycle. For configuration accesses it also raises one of four device-select lines. It then runs a single data phase and waits there for the target.

In the data phase IRDY is held high and the data-bus enable is on. The data direction follows the write flag. The C/BE lines carry the byte enables, and the target's TRDY is passed back unchanged as the processor ready. If no target claims the cycle with DEVSEL within eight data-phase clocks, a 3-bit watchdog raises the processor error so the access cannot hang the processor. A target that asserts STOP also produces a processor error.

Top module: `bus_init_seq`

States:
- IDLE: waits for a strobe.
- ADDR: the address cycle.
- DATA: waits for TRDY, STOP or timeout.

Transitions:
- IDLE to ADDR on a strobe with a supported access.
- ADDR to DATA always.
- DATA to IDLE when TRDY, STOP or timeout occurs.

## Requirements
- R1: A strobe accepted in IDLE makes the next cycle the address cycle. In that cycle, and only then, `frame` and `addr_en` are 1. The cycle after it is the first data-phase cycle.
- R2: In the address cycle `cbe` carries the command: 0110 for a memory read and 0111 for a memory write, 1010 and 1011 for configuration read and write, 0010 and 0011 for I/O read and write.
- R3: A strobe with A31 (bit 3 of `proc_addr_top`) at 0 starts nothing, and `frame` stays 0. When `proc_io` is 1 the access is I/O whatever A30 (bit 2) is. With `proc_io` at 0, A30=1 selects a configuration access and A30=0 selects a memory access.
- R4: In the address cycle of a configuration access, `idsel[k]` is 1 for k = A29:A28 (bits 1:0) and all other lines are 0. At any other time, and for other access kinds, `idsel` is 0.
- R5: After reset, and in IDLE, every bus output is 0 and `cbe` is 1111. Throughout the data phase `irdy`, `data_en` and `data_phase` are 1. The phase ends in the cycle in which TRDY, STOP or timeout occurs, and the next cycle is IDLE.
- R6: During the data phase `proc_rdy` equals `trdy` in the same cycle. Outside it, `proc_rdy` is 0.
- R7: During a data phase `cbe` is 0000 for a read and equals `proc_be_n` for a write.
- R8: `data_dir` is 1 (outward) during a write data phase and 0 during a read data phase. It is 0 whenever `data_en` is 0.
- R9: The watchdog clears at each address cycle. If `devsel` is 0 in data-phase cycles 0 to 7, `proc_err` is 1 in cycle 7 and the phase ends. If `devsel` is seen in any of those cycles, no timeout occurs and the phase lasts until TRDY or STOP.
- R10: `proc_err` is 1 in any data-phase cycle in which `stop` is 1, and the phase ends there. Outside the data phase `proc_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| proc_start | input | 1 | One-cycle access strobe, sampled in IDLE |
| proc_addr_top | input | 4 | Address bits A31:A28 |
| proc_io | input | 1 | 1 = I/O access, 0 = memory space |
| proc_wr | input | 1 | 1 = write, 0 = read |
| proc_be_n | input | 4 | Active-low processor byte enables |
| proc_rdy | output | 1 | Ready to processor (TRDY passed through) |
| proc_err | output | 1 | Error to processor (STOP or timeout) |
| trdy | input | 1 | Target ready |
| devsel | input | 1 | Target claims the cycle |
| stop | input | 1 | Target stop request |
| frame | output | 1 | Transaction frame (address cycle) |
| irdy | output | 1 | Initiator ready |
| cbe | output | 4 | Command / active-low byte enables |
| idsel | output | 4 | Configuration device selects |
| addr_en | output | 1 | Address-bus driver enable |
| data_en | output | 1 | Data-bus driver enable |
| data_dir | output | 1 | 1 = drive data outward |
| data_phase | output | 1 | Data phase in progress |

## Verification
The address-cycle outputs (`frame`, `addr_en`, command, `idsel`) are due one clock after the edge that samples the strobe. Data-phase cycle 0 follows one clock later. `proc_rdy`, `proc_err`, `cbe` and `data_dir` are combinational from the state and the target inputs, so the bench changes the target inputs just after a falling edge and samples 1 ns later, in the same cycle. The timeout is expected in the data cycle numbered 7 when no `devsel` has arrived. The return to IDLE is checked in the cycle after the completing one.

// File: rtl/bis_pkg.sv
package bis_pkg;
    typedef enum logic [1:0] {
        K_NONE = 2'd0,
        K_MEM  = 2'd1,
        K_CFG  = 2'd2,
        K_IO   = 2'd3
    } acc_kind_t;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ADDR = 2'd1,
        S_DATA = 2'd2
    } seq_state_t;

    localparam logic [3:0] CBE_IDLE = 4'b1111;
endpackage

// File: rtl/bis_decode.sv
module bis_decode
    import bis_pkg::*;
#(
    parameter int N_SEL = 4,
    localparam int SEL_W = $clog2(N_SEL)
) (
    input  logic [3:0]       addr_top,
    input  logic             io_flag,
    input  logic             wr,
    output logic             valid,
    output logic [3:0]       cmd,
    output logic [N_SEL-1:0] sel
);
    acc_kind_t kind;
    logic [SEL_W-1:0] sel_idx;

    assign sel_idx = addr_top[SEL_W-1:0];

    always_comb begin
        if (!addr_top[3])     kind = K_NONE;
        else if (io_flag)     kind = K_IO;
        else if (addr_top[2]) kind = K_CFG;
        else                  kind = K_MEM;
    end

    always_comb begin
        valid = (kind != K_NONE);
        unique case (kind)
            K_MEM:   cmd = {3'b011, wr};
            K_CFG:   cmd = {3'b101, wr};
            K_IO:    cmd = {3'b001, wr};
            default: cmd = 4'b0000;
        endcase
    end

    generate
        for (genvar k = 0; k < N_SEL; k++) begin : g_sel
            assign sel[k] = (kind == K_CFG) && (sel_idx == SEL_W'(k));
        end
    endgenerate
endmodule

// File: rtl/bis_watchdog.sv
module bis_watchdog #(
    parameter int CNT_W = 3,
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}}
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear,
    input  logic run,
    input  logic devsel,
    output logic expired
);
    logic [CNT_W-1:0] cnt;
    logic             seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (clear) begin
            cnt  <= '0;
            seen <= 1'b0;
        end else if (run) begin
            if (devsel)
                seen <= 1'b1;
            else if (!seen && cnt != CNT_MAX)
                cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && !seen && !devsel && (cnt == CNT_MAX);
endmodule

// File: rtl/bus_init_seq.sv
module bus_init_seq
    import bis_pkg::*;
#(
    parameter int N_SEL = 4,
    parameter int TMO_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             proc_start,
    input  logic [3:0]       proc_addr_top,
    input  logic             proc_io,
    input  logic             proc_wr,
    input  logic [3:0]       proc_be_n,
    output logic             proc_rdy,
    output logic             proc_err,
    input  logic             trdy,
    input  logic             devsel,
    input  logic             stop,
    output logic             frame,
    output logic             irdy,
    output logic [3:0]       cbe,
    output logic [N_SEL-1:0] idsel,
    output logic             addr_en,
    output logic             data_en,
    output logic             data_dir,
    output logic             data_phase
);
    seq_state_t       st, st_nx;
    logic             dec_valid;
    logic [3:0]       dec_cmd;
    logic [N_SEL-1:0] dec_sel;
    logic [3:0]       cmd_q;
    logic [N_SEL-1:0] sel_q;
    logic             wr_q;
    logic             tmo;
    logic             in_data;
    logic             accept;

    bis_decode #(.N_SEL(N_SEL)) u_dec (
        .addr_top (proc_addr_top),
        .io_flag  (proc_io),
        .wr       (proc_wr),
        .valid    (dec_valid),
        .cmd      (dec_cmd),
        .sel      (dec_sel)
    );

    assign in_data = (st == S_DATA);
    assign accept  = (st == S_IDLE) && proc_start && dec_valid;

    bis_watchdog #(.CNT_W(TMO_W)) u_wdg (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (st == S_ADDR),
        .run     (in_data),
        .devsel  (devsel),
        .expired (tmo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st    <= S_IDLE;
            cmd_q <= '0;
            sel_q <= '0;
            wr_q  <= 1'b0;
        end else begin
            st <= st_nx;
            if (accept) begin
                cmd_q <= dec_cmd;
                sel_q <= dec_sel;
                wr_q  <= proc_wr;
            end
        end
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            S_IDLE: if (accept) st_nx = S_ADDR;
            S_ADDR: st_nx = S_DATA;
            S_DATA: if (trdy || stop || tmo) st_nx = S_IDLE;
            default: st_nx = S_IDLE;
        endcase
    end

    always_comb begin
        frame      = 1'b0;
        addr_en    = 1'b0;
        irdy       = 1'b0;
        data_en    = 1'b0;
        data_dir   = 1'b0;
        data_phase = 1'b0;
        idsel      = '0;
        cbe        = CBE_IDLE;
        proc_rdy   = 1'b0;
        proc_err   = 1'b0;
        unique case (st)
            S_IDLE: ;
            S_ADDR: begin
                frame   = 1'b1;
                addr_en = 1'b1;
                cbe     = cmd_q;
                idsel   = sel_q;
            end
            S_DATA: begin
                irdy       = 1'b1;
                data_en    = 1'b1;
                data_phase = 1'b1;
                data_dir   = wr_q;
                cbe        = wr_q ? proc_be_n : 4'b0000;
                proc_rdy   = trdy;
                proc_err   = stop || tmo;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/bis_checker.sv
module bis_checker #(
    parameter int N_SEL = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             proc_rdy,
    input logic             proc_err,
    input logic             trdy,
    input logic             devsel,
    input logic             stop,
    input logic             frame,
    input logic             addr_en,
    input logic [N_SEL-1:0] idsel,
    input logic             data_en,
    input logic             data_dir,
    input logic             data_phase
);
    logic [3:0] nodev_cnt;
    logic       dev_seen;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nodev_cnt <= '0;
            dev_seen  <= 1'b0;
        end else if (addr_en) begin
            nodev_cnt <= '0;
            dev_seen  <= 1'b0;
        end else if (data_phase) begin
            if (devsel) dev_seen <= 1'b1;
            else if (!dev_seen) nodev_cnt <= nodev_cnt + 1'b1;
        end
    end

    assert_addr_single_R1: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en |=> (!addr_en && data_phase));
    assert_frame_addr_R1: assert property (@(posedge clk) disable iff (!rst_n)
        frame |-> addr_en);
    assert_idsel_onehot_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(idsel) && ((idsel == '0) || addr_en));
    assert_hold_data_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && !trdy && !stop && !proc_err) |=> data_phase);
    assert_rdy_phase_R6: assert property (@(posedge clk) disable iff (!rst_n)
        proc_rdy |-> (data_phase && trdy));
    assert_dir_valid_R8: assert property (@(posedge clk) disable iff (!rst_n)
        data_dir |-> data_en);
    assert_timeout_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
        data_phase |-> (nodev_cnt < 4'd8));
    assert_stop_err_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (data_phase && stop) |-> proc_err);
    assert_err_phase_R10: assert property (@(posedge clk) disable iff (!rst_n)
        proc_err |-> data_phase);
endmodule

bind bus_init_seq bis_checker #(.N_SEL(N_SEL)) u_bis_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .proc_rdy   (proc_rdy),
    .proc_err   (proc_err),
    .trdy       (trdy),
    .devsel     (devsel),
    .stop       (stop),
    .frame      (frame),
    .addr_en    (addr_en),
    .idsel      (idsel),
    .data_en    (data_en),
    .data_dir   (data_dir),
    .data_phase (data_phase)
);

// File: tb/test_bus_init_seq.sv
module test_bus_init_seq;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       proc_start = 1'b0;
    logic [3:0] proc_addr_top = '0;
    logic       proc_io = 1'b0;
    logic       proc_wr = 1'b0;
    logic [3:0] proc_be_n = 4'hF;
    logic       trdy = 1'b0, devsel = 1'b0, stop = 1'b0;
    logic       proc_rdy, proc_err, frame, irdy, addr_en, data_en, data_dir, data_phase;
    logic [3:0] cbe, idsel;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bus_init_seq i_bus_init_seq (
        .clk(clk), .rst_n(rst_n), .proc_start(proc_start), .proc_addr_top(proc_addr_top),
        .proc_io(proc_io), .proc_wr(proc_wr), .proc_be_n(proc_be_n),
        .proc_rdy(proc_rdy), .proc_err(proc_err), .trdy(trdy), .devsel(devsel), .stop(stop),
        .frame(frame), .irdy(irdy), .cbe(cbe), .idsel(idsel), .addr_en(addr_en),
        .data_en(data_en), .data_dir(data_dir), .data_phase(data_phase)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [3:0] exp_cmd(input logic [3:0] a, input logic io, input logic wr);
        if (!a[3])    return 4'hF;
        if (io)       return {3'b001, wr};
        if (a[2])     return {3'b101, wr};
        return {3'b011, wr};
    endfunction

    function automatic logic [3:0] exp_sel(input logic [3:0] a, input logic io);
        if (a[3] && !io && a[2]) return 4'b0001 << a[1:0];
        return 4'b0000;
    endfunction

    task automatic check_idle(input string req);
        chk({frame, addr_en, irdy, data_en, data_dir, data_phase, proc_rdy, proc_err} == 8'd0,
            req, {frame, addr_en, irdy, data_en, data_dir, data_phase, proc_rdy, proc_err}, 0);
        chk(cbe == 4'hF && idsel == 4'h0, req, {cbe, idsel}, 8'hF0);
    endtask

    // dsel_at: first data cycle with devsel (>7 = never before timeout)
    task automatic run_txn(input logic [3:0] a, input logic io, input logic wr,
                           input logic [3:0] be, input int dsel_at, input int trdy_at,
                           input int stop_at);
        @(negedge clk);
        proc_start = 1'b1; proc_addr_top = a; proc_io = io; proc_wr = wr; proc_be_n = be;
        #1;
        check_idle("R5 idle before start");
        @(negedge clk);
        proc_start = 1'b0;
        #1;
        if (!a[3]) begin
            chk(frame == 1'b0 && addr_en == 1'b0, "R3 A31=0 ignored", {frame, addr_en}, 0);
            return;
        end
        chk(frame && addr_en && !data_phase, "R1 address cycle", {frame, addr_en, data_phase}, 3'b110);
        chk(cbe == exp_cmd(a, io, wr), "R2 command", cbe, exp_cmd(a, io, wr));
        chk(idsel == exp_sel(a, io), "R4 idsel", idsel, exp_sel(a, io));
        for (int i = 0; i < 40; i++) begin
            bit dv, tr, sp, tmo;
            @(negedge clk);
            dv = (i >= dsel_at); tr = (i == trdy_at); sp = (i == stop_at);
            devsel = dv; trdy = tr; stop = sp;
            tmo = (i == 7) && (dsel_at > 7);
            #1;
            chk(!frame && !addr_en && irdy && data_en && data_phase, "R5 data phase",
                {frame, addr_en, irdy, data_en, data_phase}, 5'b00111);
            chk(idsel == 4'h0, "R4 idsel off in data", idsel, 0);
            chk(proc_rdy == tr, "R6 ready passthrough", proc_rdy, tr);
            chk(cbe == (wr ? be : 4'h0), "R7 data cbe", cbe, wr ? be : 4'h0);
            chk(data_dir == wr, "R8 direction", data_dir, wr);
            if (sp) chk(proc_err == 1'b1, "R10 stop error", proc_err, 1);
            else    chk(proc_err == tmo, "R9 timeout error", proc_err, tmo);
            if (tr || sp || tmo) break;
        end
        @(negedge clk);
        devsel = 1'b0; trdy = 1'b0; stop = 1'b0;
        #1;
        check_idle("R5 idle after end");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        #1;
        check_idle("R5 reset state");
        rst_n = 1'b1;
        // directed
        run_txn(4'b1000, 1'b0, 1'b0, 4'h3, 0, 1, 99);   // memory read R2 R7
        run_txn(4'b1000, 1'b0, 1'b1, 4'h5, 1, 3, 99);   // memory write R8
        for (int s = 0; s < 4; s++)
            run_txn({2'b11, 2'(s)}, 1'b0, s[0], 4'hA, 0, 0, 99); // config R4
        run_txn(4'b1111, 1'b1, 1'b0, 4'h0, 2, 2, 99);   // I/O, A30 ignored R3
        run_txn(4'b1011, 1'b1, 1'b1, 4'h9, 0, 2, 99);   // I/O write
        run_txn(4'b0110, 1'b0, 1'b0, 4'h0, 0, 0, 99);   // A31=0 R3
        run_txn(4'b1000, 1'b0, 1'b0, 4'h0, 7, 12, 99);  // devsel in last allowed cycle R9
        run_txn(4'b1000, 1'b0, 1'b1, 4'h1, 99, 99, 99); // no devsel -> timeout R9
        run_txn(4'b1100, 1'b0, 1'b0, 4'h0, 0, 99, 3);   // stop R10
        // constrained random
        for (int n = 0; n < 300; n++) begin
            int k, ds, tr, sp;
            logic [3:0] a;
            logic io;
            k = int'($urandom % 4);
            a = 4'($urandom);
            io = 1'b0;
            case (k)
                0: a[3:2] = 2'b10;
                1: a[3:2] = 2'b11;
                2: begin a[3] = 1'b1; io = 1'b1; end
                default: a[3] = ($urandom % 8) == 0 ? 1'b0 : 1'b1;
            endcase
            ds = int'($urandom % 11);
            tr = (ds > 7) ? 99 : ds + int'($urandom % 3);
            sp = (($urandom % 5) == 0) ? ds + int'($urandom % 2) : 99;
            if (ds > 7) sp = 99;
            run_txn(a, io, 1'($urandom), 4'($urandom), ds, tr, sp);
        end
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule